// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers six level signals from neighbouring logic, such as the low and high bits of a parallel port's control byte or a counter's output, and turns their rising edges into sticky status bits. Each source has an enable bit. A source can set its status bit only while it is enabled. There is no separate clear register: software clears a status bit by clearing that source's enable bit.

A single interrupt request line rises when the status word changes from all-zero to non-zero. It stays high until every status bit has been cleared. Software writes the enable register and reads both registers through a small register port.

A combinational packing helper takes a list of up to six source indices and builds a 16-bit word from the current status. Bit k of the word is the status of the k-th listed source. This lets a streaming reader pick out only the sources it asked for.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, the status register reads 0x00, `irq_o` is low and `pack_o` is 0x0000.
- R2: A rising edge on `src_i[n]` sets status bit n when enable bit n is set. Each source passes through two synchroniser flops before edge detection, so the bit becomes visible 3 clock edges after the input rises. An edge on a disabled source is ignored.
- R3: A set status bit stays set while its enable bit stays set, whatever the source does afterwards.
- R4: Writing 0 to enable bit n clears status bit n on the clock edge that captures the write. No other way to clear a status bit exists.
- R5: If an edge is detected in the same cycle as a write that disables that source, the edge is dropped and the clear wins.
- R6: `irq_o` rises on the clock edge where the status word goes from zero to non-zero. It stays high while any status bit is set and falls once all bits are clear.
- R7: Register address 0 is the enable register, and writes take `reg_wdata_i[5:0]`. Address 1 is the read-only status register, and writes to it have no effect. Reads return the six bits in `reg_rdata_o[5:0]` with bits 7:6 zero, combinationally, and have no side effects.
- R8: `pack_o` bit k equals the status bit of the source index held in `chan_list_i[3k+2:3k]`, for k below the list length. Bits at or above the length read as zero, and a length above 6 is treated as 6.
- R9: In `pack_o`, a list entry of 6 or 7 names no source and packs as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Asynchronous interrupt source levels |
| reg_addr_i | input | 1 | Register select: 0 enable, 1 status |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 6 | Write data |
| reg_rdata_o | output | 8 | Read data, zero-extended |
| irq_o | output | 1 | Interrupt request |
| chan_list_i | input | 18 | Six 3-bit source indices, entry k at bits 3k+2:3k |
| chan_len_i | input | 3 | Number of valid list entries |
| pack_o | output | 16 | Packed status word |

## Verification
The hardest case to reach is the collision between a detected edge and a disabling write. The edge exists inside the design for only one cycle, two flops after the pin. To reach it, the stimulus raises a source on a known falling clock edge, counts two rising edges, and then places the disable write so that it is captured on the third. It then re-enables the source while the input is still high. The status bit must stay at zero, which shows the edge was not merely hidden by the clear but was dropped.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int NUM_SRC  = 6;
  localparam int IDX_W    = 3;
  localparam int LIST_MAX = 6;
  localparam int LEN_W    = 3;
  localparam int PACK_W   = 16;
  localparam int RDATA_W  = 8;
  localparam int SYNC_STG = 2;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int W   = 6,
  parameter int STG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  // STG synchroniser flops plus one history flop for edge detection
  logic [W-1:0] stg_q [STG+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= STG; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= src_i;
      for (int i = 1; i <= STG; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign rise_o = stg_q[STG-1] & ~stg_q[STG];
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] en_q, en_d, status_q, status_d;
  logic         irq_q;

  assign en_d = en_wr_i ? en_wdata_i : en_q;
  // an edge counts only if enabled both before and after this cycle's write
  assign status_d = (status_q | (rise_i & en_q)) & en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      en_q     <= en_d;
      status_q <= status_d;
      irq_q    <= |status_d;
    end
  end

  assign en_o     = en_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & en_q) != '0) |=>
      ((status_q & $past(status_q & en_q & en_d)) == $past(status_q & en_q & en_d)));

  a_r4_clear_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~en_q) == '0);

  a_r2_set_only_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_i & en_q)) == '0));

  a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ($past(status_q) == '0 && status_q != '0));

  a_r6_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (status_q != '0));
endmodule

// File: rtl/irq_stream_pack.sv
module irq_stream_pack #(
  parameter int W        = 6,
  parameter int IDX_W    = 3,
  parameter int LIST_MAX = 6,
  parameter int LEN_W    = 3,
  parameter int PACK_W   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              status_i,
  input  logic [LIST_MAX*IDX_W-1:0] list_i,
  input  logic [LEN_W-1:0]          len_i,
  output logic [PACK_W-1:0]         pack_o
);
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_i > LEN_W'(LIST_MAX)) ? LEN_W'(LIST_MAX) : len_i;

  for (genvar k = 0; k < PACK_W; k++) begin : g_bit
    if (k < LIST_MAX) begin : g_used
      logic [IDX_W-1:0] idx;
      assign idx = list_i[k*IDX_W +: IDX_W];
      assign pack_o[k] = (LEN_W'(k) < len_eff) && (idx < IDX_W'(W)) && status_i[idx];
    end else begin : g_zero
      assign pack_o[k] = 1'b0;
    end
  end

  a_r8_above_len_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pack_o >> len_eff) == '0);

  a_r8_no_bits_without_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == '0) |-> (pack_o == '0));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        src_i,
  input  logic                      reg_addr_i,
  input  logic                      reg_wr_i,
  input  logic [NUM_SRC-1:0]        reg_wdata_i,
  output logic [RDATA_W-1:0]        reg_rdata_o,
  output logic                      irq_o,
  input  logic [LIST_MAX*IDX_W-1:0] chan_list_i,
  input  logic [LEN_W-1:0]          chan_len_i,
  output logic [PACK_W-1:0]         pack_o
);
  logic [NUM_SRC-1:0] rise, en, status;
  logic               en_wr;

  assign en_wr = reg_wr_i && (reg_addr_i == 1'b0);

  irq_src_sync #(.W(NUM_SRC), .STG(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .src_i, .rise_o(rise)
  );

  irq_status_latch #(.W(NUM_SRC)) u_latch (
    .clk_i, .rst_ni, .rise_i(rise), .en_wr_i(en_wr), .en_wdata_i(reg_wdata_i),
    .en_o(en), .status_o(status), .irq_o
  );

  irq_stream_pack #(
    .W(NUM_SRC), .IDX_W(IDX_W), .LIST_MAX(LIST_MAX), .LEN_W(LEN_W), .PACK_W(PACK_W)
  ) u_pack (
    .clk_i, .rst_ni, .status_i(status), .list_i(chan_list_i),
    .len_i(chan_len_i), .pack_o
  );

  assign reg_rdata_o = RDATA_W'(reg_addr_i ? status : en);

  a_r7_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i) |=> $stable(en));
endmodule

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src = '0;
  logic        addr = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [17:0] list = '0;
  logic [2:0]  len = '0;
  logic [15:0] pack;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .chan_list_i(list),
    .chan_len_i(len), .pack_o(pack)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [5:0] v);
    addr = 1'b0; wdata = v; wr = 1'b1;
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulse(input logic [5:0] m);
    src = src | m; cyc(2);
    src = src & ~m; cyc(3);
  endtask

  task automatic mk_list(input logic [2:0] e0, e1, e2, e3, e4, e5);
    list = {e5, e4, e3, e2, e1, e0};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v); chk("R1 enable", 16'(v), 16'h00);
    rd(1'b1, v); chk("R1 status", 16'(v), 16'h00);
    chk("R1 irq", 16'(irq), 16'h0);
    mk_list(0, 1, 2, 3, 4, 5); len = 3'd6; #1;
    chk("R1 pack", pack, 16'h0000);
  endtask

  task automatic t_edge_set;
    logic [7:0] v;
    pulse(6'b000100);
    rd(1'b1, v); chk("R2 disabled edge ignored", 16'(v), 16'h00);
    wr_en(6'b000101);
    src[0] = 1'b1;
    cyc(2); rd(1'b1, v); chk("R2 not yet after 2 edges", 16'(v), 16'h00);
    cyc(1); rd(1'b1, v); chk("R2 set after 3 edges", 16'(v), 16'h01);
    chk("R6 irq rises with status", 16'(irq), 16'h1);
    src[0] = 1'b0; cyc(4);
    rd(1'b1, v); chk("R3 sticky after source falls", 16'(v), 16'h01);
    pulse(6'b000001);
    rd(1'b1, v); chk("R3 stays set on second edge", 16'(v), 16'h01);
    rd(1'b1, v); chk("R7 read has no side effect", 16'(v), 16'h01);
  endtask

  task automatic t_clear_irq;
    logic [7:0] v;
    pulse(6'b000100);
    rd(1'b1, v); chk("R2 second source", 16'(v), 16'h05);
    wr_en(6'b000100);
    rd(1'b1, v); chk("R4 disable clears bit", 16'(v), 16'h04);
    chk("R6 irq held while nonzero", 16'(irq), 16'h1);
    wr_en(6'b000000);
    rd(1'b1, v); chk("R4 all clear", 16'(v), 16'h00);
    chk("R6 irq falls when zero", 16'(irq), 16'h0);
    wr_en(6'b000100);
    rd(1'b1, v); chk("R4 reenable does not restore", 16'(v), 16'h00);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    wr_en(6'b000010);
    src[1] = 1'b1;
    cyc(2);
    addr = 1'b0; wdata = 6'b000000; wr = 1'b1;
    cyc(1);
    wr = 1'b0;
    rd(1'b1, v); chk("R5 clear wins", 16'(v), 16'h00);
    wr_en(6'b000010); cyc(3);
    rd(1'b1, v); chk("R5 edge dropped", 16'(v), 16'h00);
    chk("R5 irq low", 16'(irq), 16'h0);
    src[1] = 1'b0; cyc(3);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr_en(6'b111111);
    rd(1'b0, v); chk("R7 enable readback", 16'(v), 16'h3F);
    addr = 1'b1; wdata = 6'b000000; wr = 1'b1; cyc(1); wr = 1'b0;
    rd(1'b0, v); chk("R7 status write ignored", 16'(v), 16'h3F);
    pulse(6'b101001);
    rd(1'b1, v); chk("R7 status zero-extended", 16'(v), 16'h29);
  endtask

  task automatic t_pack;
    mk_list(5, 0, 3, 1, 2, 4); len = 3'd3; #1;
    chk("R8 order", pack, 16'h0007);
    len = 3'd6; #1;
    chk("R8 full list", pack, 16'h0007);
    mk_list(1, 5, 2, 0, 4, 3); len = 3'd6; #1;
    chk("R8 reorder", pack, 16'h002A);
    len = 3'd2; #1;
    chk("R8 above length zero", pack, 16'h0002);
    len = 3'd7; #1;
    chk("R8 length clamp", pack, 16'h002A);
    mk_list(6, 7, 0, 6, 7, 5); len = 3'd6; #1;
    chk("R9 bad index zero", pack, 16'h0024);
    len = 3'd0; #1;
    chk("R8 empty list", pack, 16'h0000);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(2);
    t_reset;
    t_edge_set;
    t_clear_irq;
    t_collision;
    t_regs;
    t_pack;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule